// File: doc/BRIEF.md
# Virtualization Intercept Decision Unit

This block decides, for every guest event presented to it, whether the event must force an exit back to the host. When the guest starts running, a single load strobe captures six intercept masks: control-register read, control-register write, debug-register read, debug-register write, exception, and a 64-bit general vector. The same strobe arms a global intercept-active flag. A strobe marking the return to the host disarms that flag and wipes the general vector and the exception mask.

An event carries an exit code and a 64-bit parameter. The single exit-code space is split into disjoint ranges, and each range is backed by its own mask. The unit works out which range the code falls in and tests the mask bit at (code minus range base). On a hit it issues a one-cycle exit request that carries the original code and parameter. After a request, the unit ignores further events until the host either re-enters the guest or acknowledges the exit.

Top module: `vx_intercept_unit`

## Requirements
- R1: After reset `exit_req` is low and the intercept-active flag is clear. Until the first `entry_load`, no event produces an exit.
- R2: While the intercept-active flag is clear, no event produces an exit, whatever its code or the mask contents.
- R3: Codes 0x000 to 0x008 exit when bit (code − 0x000) of the 16-bit `mask_cr_rd` is set. Codes 0x010 to 0x018 exit when bit (code − 0x010) of the 16-bit `mask_cr_wr` is set.
- R4: Codes 0x020 to 0x027 exit when bit (code − 0x020) of the 16-bit `mask_dr_rd` is set. Codes 0x030 to 0x037 exit when bit (code − 0x030) of the 16-bit `mask_dr_wr` is set.
- R5: Codes 0x040 to 0x05F exit when bit (code − 0x040) of the 32-bit `mask_exc` is set.
- R6: Codes 0x060 to 0x09F exit when bit (code − 0x060) of the 64-bit `mask_gen` is set. Codes outside every range never exit. These include 0x009–0x00F, 0x019–0x01F, 0x028–0x02F, 0x038–0x03F and anything at or above 0x0A0.
- R7: `entry_load` captures all six masks and sets the intercept-active flag. `exit_done` clears the flag, the general vector and the exception mask. After `exit_done`, events do not exit until the next `entry_load`.
- R8: An event accepted on a clock edge with `evt_valid` high, if it hits, raises `exit_req` for exactly the following cycle. During that cycle `exit_code` and `exit_param` equal the event's code and parameter unchanged.
- R9: Once an exit has been requested, events are ignored until `entry_load` or `exit_done`. In particular, `exit_req` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| entry_load | input | 1 | Guest entry: capture masks, arm intercepts, clear pending exit |
| mask_cr_rd | input | 16 | Control-register read intercept mask |
| mask_cr_wr | input | 16 | Control-register write intercept mask |
| mask_dr_rd | input | 16 | Debug-register read intercept mask |
| mask_dr_wr | input | 16 | Debug-register write intercept mask |
| mask_exc | input | 32 | Exception intercept mask |
| mask_gen | input | 64 | General intercept vector |
| exit_done | input | 1 | Return to host: disarm, clear general and exception masks, clear pending exit |
| evt_valid | input | 1 | Event strobe |
| evt_code | input | CODE_W (12) | Event exit code |
| evt_param | input | PARAM_W (64) | Event parameter |
| exit_req | output | 1 | One-cycle exit request |
| exit_code | output | CODE_W (12) | Code of the event that caused the exit |
| exit_param | output | PARAM_W (64) | Parameter of the event that caused the exit |

## Verification
The assertions assume that `entry_load` and `exit_done` are never asserted in the same cycle as an `evt_valid` that should be judged against freshly loaded masks. They also assume that `evt_code` and `evt_param` are driven with known values from the start, with no X. The stimulus keeps to these assumptions in three ways. It drives every input from reset onward. It issues each event on its own cycle. It pulses `entry_load` only between events, to re-arm the unit and clear a pending exit. The sweep then covers every code from 0x000 to 0x0AF, plus a few high codes, under an all-ones mask set and two complementary bit patterns.

// File: rtl/vx_intercept_pkg.sv
package vx_intercept_pkg;

   localparam int unsigned CRDR_W = 16;
   localparam int unsigned EXC_W  = 32;
   localparam int unsigned GEN_W  = 64;

   localparam int unsigned NUM_SPEC = 5;

   localparam int unsigned DEF_CR_RD_BASE = 'h000;
   localparam int unsigned DEF_CR_WR_BASE = 'h010;
   localparam int unsigned DEF_DR_RD_BASE = 'h020;
   localparam int unsigned DEF_DR_WR_BASE = 'h030;
   localparam int unsigned DEF_EXC_BASE   = 'h040;
   localparam int unsigned DEF_GEN_BASE   = 'h060;

   typedef struct packed {
      logic [CRDR_W-1:0] cr_rd;
      logic [CRDR_W-1:0] cr_wr;
      logic [CRDR_W-1:0] dr_rd;
      logic [CRDR_W-1:0] dr_wr;
      logic [EXC_W-1:0]  exc;
      logic [GEN_W-1:0]  gen;
   } vx_masks_t;

   function automatic int unsigned spec_span(input int unsigned idx);
      case (idx)
         0, 1:    return 9;
         2, 3:    return 8;
         default: return 32;
      endcase
   endfunction

   function automatic int unsigned spec_mask_w(input int unsigned idx);
      return (idx < 4) ? CRDR_W : EXC_W;
   endfunction

endpackage

// File: rtl/vx_range_probe.sv
module vx_range_probe #(
   parameter int unsigned CODE_W = 12,
   parameter int unsigned BASE   = 0,
   parameter int unsigned SPAN   = 9,
   parameter int unsigned MASK_W = 16
) (
   input  logic [CODE_W-1:0] code,
   input  logic [MASK_W-1:0] mask,
   output logic              in_rng,
   output logic              hit
);

   localparam int unsigned IDX_W = (MASK_W > 1) ? $clog2(MASK_W) : 1;

   if (SPAN > MASK_W) begin : g_bad_span
      $error("range span exceeds its mask width");
   end
   if (IDX_W > CODE_W) begin : g_bad_idx
      $error("mask index wider than the exit code");
   end
   if ((BASE + SPAN) > (1 << CODE_W)) begin : g_bad_base
      $error("range does not fit in the exit-code space");
   end

   logic [CODE_W-1:0] offset;

   always_comb begin
      offset = code - CODE_W'(BASE);
      in_rng = (code >= CODE_W'(BASE)) && (offset < CODE_W'(SPAN));
      hit    = in_rng && mask[offset[IDX_W-1:0]];
   end

endmodule

// File: rtl/vx_classify.sv
module vx_classify
   import vx_intercept_pkg::*;
#(
   parameter int unsigned CODE_W     = 12,
   parameter int unsigned CR_RD_BASE = DEF_CR_RD_BASE,
   parameter int unsigned CR_WR_BASE = DEF_CR_WR_BASE,
   parameter int unsigned DR_RD_BASE = DEF_DR_RD_BASE,
   parameter int unsigned DR_WR_BASE = DEF_DR_WR_BASE,
   parameter int unsigned EXC_BASE   = DEF_EXC_BASE,
   parameter int unsigned GEN_BASE   = DEF_GEN_BASE
) (
   input  logic [CODE_W-1:0] code,
   input  vx_masks_t         masks,
   output logic              hit,
   output logic [NUM_SPEC:0] rng_vec
);

   function automatic int unsigned base_of(input int unsigned idx);
      case (idx)
         0:       return CR_RD_BASE;
         1:       return CR_WR_BASE;
         2:       return DR_RD_BASE;
         3:       return DR_WR_BASE;
         default: return EXC_BASE;
      endcase
   endfunction

   logic [EXC_W-1:0]    spec_mask [NUM_SPEC];
   logic [NUM_SPEC-1:0] in_spec;
   logic [NUM_SPEC-1:0] hit_spec;
   logic                gen_in;
   logic                gen_hit;

   assign spec_mask[0] = EXC_W'(masks.cr_rd);
   assign spec_mask[1] = EXC_W'(masks.cr_wr);
   assign spec_mask[2] = EXC_W'(masks.dr_rd);
   assign spec_mask[3] = EXC_W'(masks.dr_wr);
   assign spec_mask[4] = masks.exc;

   for (genvar gi = 0; gi < NUM_SPEC; gi++) begin : g_spec
      localparam int unsigned MW = spec_mask_w(gi);
      vx_range_probe #(
         .CODE_W (CODE_W),
         .BASE   (base_of(gi)),
         .SPAN   (spec_span(gi)),
         .MASK_W (MW)
      ) u_probe (
         .code   (code),
         .mask   (spec_mask[gi][MW-1:0]),
         .in_rng (in_spec[gi]),
         .hit    (hit_spec[gi])
      );
   end

   vx_range_probe #(
      .CODE_W (CODE_W),
      .BASE   (GEN_BASE),
      .SPAN   (GEN_W),
      .MASK_W (GEN_W)
   ) u_gen_probe (
      .code   (code),
      .mask   (masks.gen),
      .in_rng (gen_in),
      .hit    (gen_hit)
   );

   // A dedicated range always overrides the general vector.
   always_comb begin
      if (|in_spec) hit = |hit_spec;
      else          hit = gen_hit;
      rng_vec = {gen_in & ~(|in_spec), in_spec};
   end

endmodule

// File: rtl/vx_mask_bank.sv
module vx_mask_bank
   import vx_intercept_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      entry_load,
   input  logic      exit_done,
   input  vx_masks_t load_masks,
   output vx_masks_t masks_q,
   output logic      active_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         masks_q  <= '0;
         active_q <= 1'b0;
      end else if (entry_load) begin
         masks_q  <= load_masks;
         active_q <= 1'b1;
      end else if (exit_done) begin
         masks_q.gen <= '0;
         masks_q.exc <= '0;
         active_q    <= 1'b0;
      end
   end

   assert_exit_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (exit_done && !entry_load) |=> (!active_q && masks_q.gen == '0 && masks_q.exc == '0));

   assert_entry_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
      entry_load |=> (active_q && masks_q == $past(load_masks)));

endmodule

// File: rtl/vx_exit_stage.sv
module vx_exit_stage #(
   parameter int unsigned CODE_W  = 12,
   parameter int unsigned PARAM_W = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               evt_valid,
   input  logic               hit,
   input  logic               active,
   input  logic               entry_load,
   input  logic               exit_done,
   input  logic [CODE_W-1:0]  evt_code,
   input  logic [PARAM_W-1:0] evt_param,
   output logic               exit_req,
   output logic [CODE_W-1:0]  exit_code,
   output logic [PARAM_W-1:0] exit_param,
   output logic               pending_q
);

   logic fire;

   assign fire = evt_valid && active && !pending_q && hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         exit_req   <= 1'b0;
         pending_q  <= 1'b0;
         exit_code  <= '0;
         exit_param <= '0;
      end else begin
         exit_req  <= fire;
         pending_q <= fire || (pending_q && !(entry_load || exit_done));
         if (fire) begin
            exit_code  <= evt_code;
            exit_param <= evt_param;
         end
      end
   end

   assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      exit_req |=> !exit_req);

   assert_pending_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pending_q |=> !exit_req);

endmodule

// File: rtl/vx_intercept_unit.sv
module vx_intercept_unit
   import vx_intercept_pkg::*;
#(
   parameter int unsigned CODE_W     = 12,
   parameter int unsigned PARAM_W    = 64,
   parameter int unsigned CR_RD_BASE = DEF_CR_RD_BASE,
   parameter int unsigned CR_WR_BASE = DEF_CR_WR_BASE,
   parameter int unsigned DR_RD_BASE = DEF_DR_RD_BASE,
   parameter int unsigned DR_WR_BASE = DEF_DR_WR_BASE,
   parameter int unsigned EXC_BASE   = DEF_EXC_BASE,
   parameter int unsigned GEN_BASE   = DEF_GEN_BASE
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               entry_load,
   input  logic [15:0]        mask_cr_rd,
   input  logic [15:0]        mask_cr_wr,
   input  logic [15:0]        mask_dr_rd,
   input  logic [15:0]        mask_dr_wr,
   input  logic [31:0]        mask_exc,
   input  logic [63:0]        mask_gen,
   input  logic               exit_done,
   input  logic               evt_valid,
   input  logic [CODE_W-1:0]  evt_code,
   input  logic [PARAM_W-1:0] evt_param,
   output logic               exit_req,
   output logic [CODE_W-1:0]  exit_code,
   output logic [PARAM_W-1:0] exit_param
);

   if (CODE_W < 8) begin : g_bad_code_w
      $error("exit code too narrow for the range layout");
   end
   if (PARAM_W < 1) begin : g_bad_param_w
      $error("parameter width must be positive");
   end

   vx_masks_t           load_masks;
   vx_masks_t           masks_q;
   logic                active_q;
   logic                hit;
   logic                pending_q;
   logic [NUM_SPEC:0]   rng_vec;

   assign load_masks = '{cr_rd: mask_cr_rd, cr_wr: mask_cr_wr,
                         dr_rd: mask_dr_rd, dr_wr: mask_dr_wr,
                         exc: mask_exc, gen: mask_gen};

   vx_mask_bank u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .entry_load (entry_load),
      .exit_done  (exit_done),
      .load_masks (load_masks),
      .masks_q    (masks_q),
      .active_q   (active_q)
   );

   vx_classify #(
      .CODE_W     (CODE_W),
      .CR_RD_BASE (CR_RD_BASE),
      .CR_WR_BASE (CR_WR_BASE),
      .DR_RD_BASE (DR_RD_BASE),
      .DR_WR_BASE (DR_WR_BASE),
      .EXC_BASE   (EXC_BASE),
      .GEN_BASE   (GEN_BASE)
   ) u_cls (
      .code    (evt_code),
      .masks   (masks_q),
      .hit     (hit),
      .rng_vec (rng_vec)
   );

   vx_exit_stage #(
      .CODE_W  (CODE_W),
      .PARAM_W (PARAM_W)
   ) u_exit (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_valid  (evt_valid),
      .hit        (hit),
      .active     (active_q),
      .entry_load (entry_load),
      .exit_done  (exit_done),
      .evt_code   (evt_code),
      .evt_param  (evt_param),
      .exit_req   (exit_req),
      .exit_code  (exit_code),
      .exit_param (exit_param),
      .pending_q  (pending_q)
   );

   assert_inactive_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !active_q |=> !exit_req);

   assert_code_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
      exit_req |-> exit_code == $past(evt_code));

   assert_param_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
      exit_req |-> exit_param == $past(evt_param));

   assert_needs_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_valid |=> !exit_req);

   assert_disjoint_ranges_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rng_vec));

   assert_no_range_no_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rng_vec == '0) |=> !exit_req);

endmodule

// File: tb/vx_intercept_unit_tb_top.sv
module vx_intercept_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        entry_load = 1'b0;
   logic [15:0] m_crr = '0, m_crw = '0, m_drr = '0, m_drw = '0;
   logic [31:0] m_exc = '0;
   logic [63:0] m_gen = '0;
   logic        exit_done = 1'b0;
   logic        evt_valid = 1'b0;
   logic [11:0] evt_code = '0;
   logic [63:0] evt_param = '0;
   logic        exit_req;
   logic [11:0] exit_code;
   logic [63:0] exit_param;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   vx_intercept_unit dut_i (
      .clk(clk), .rst_n(rst_n), .entry_load(entry_load),
      .mask_cr_rd(m_crr), .mask_cr_wr(m_crw), .mask_dr_rd(m_drr), .mask_dr_wr(m_drw),
      .mask_exc(m_exc), .mask_gen(m_gen), .exit_done(exit_done),
      .evt_valid(evt_valid), .evt_code(evt_code), .evt_param(evt_param),
      .exit_req(exit_req), .exit_code(exit_code), .exit_param(exit_param)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic bit exp_hit(input int c);
      if (c <= 8)                 return m_crr[c];
      if (c >= 16 && c <= 24)     return m_crw[c-16];
      if (c >= 32 && c <= 39)     return m_drr[c-32];
      if (c >= 48 && c <= 55)     return m_drw[c-48];
      if (c >= 64 && c <= 95)     return m_exc[c-64];
      if (c >= 96 && c <= 159)    return m_gen[c-96];
      return 1'b0;
   endfunction

   function automatic string req_of(input int c);
      if (c <= 8 || (c >= 16 && c <= 24))               return "R3";
      if ((c >= 32 && c <= 39) || (c >= 48 && c <= 55)) return "R4";
      if (c >= 64 && c <= 95)                           return "R5";
      return "R6";
   endfunction

   task automatic do_load();
      @(negedge clk) entry_load = 1'b1;
      @(negedge clk) entry_load = 1'b0;
   endtask

   task automatic do_exit_done();
      @(negedge clk) exit_done = 1'b1;
      @(negedge clk) exit_done = 1'b0;
   endtask

   // Event on one edge; exit_req is valid from that edge, sampled at the next negedge.
   task automatic do_evt(input int c, input logic [63:0] p);
      @(negedge clk);
      evt_valid = 1'b1;
      evt_code  = 12'(c);
      evt_param = p;
      @(negedge clk);
      evt_valid = 1'b0;
   endtask

   function automatic logic [63:0] param_of(input int c);
      return 64'hC0DE_0000_0000_0000 ^ (64'(c) * 64'h0001_0203_0405);
   endfunction

   task automatic sweep();
      for (int c = 0; c < 'hB0 + 3; c++) begin
         int code = (c < 'hB0) ? c : ((c == 'hB0) ? 'h100 : ((c == 'hB1) ? 'h7FF : 'hFFF));
         bit e = exp_hit(code);
         do_evt(code, param_of(code));
         chk(req_of(code), 64'(exit_req), 64'(e));
         if (e) begin
            chk("R8 code", 64'(exit_code), 64'(code));
            chk("R8 param", exit_param, param_of(code));
            @(negedge clk);
            chk("R9 pulse", 64'(exit_req), 64'd0);
            do_load();
         end
      end
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset", 64'(exit_req), 64'd0);

      // R1/R2: not armed yet, masks on the pins but never loaded
      m_crr = '1; m_crw = '1; m_drr = '1; m_drw = '1; m_exc = '1; m_gen = '1;
      for (int c = 0; c < 'hA0; c += 7) begin
         do_evt(c, param_of(c));
         chk("R2 idle", 64'(exit_req), 64'd0);
      end

      // Pattern A: all ones
      do_load();
      sweep();

      // Pattern B and its complement
      m_crr = 16'h0155; m_crw = 16'h00AA; m_drr = 16'h0069; m_drw = 16'h0096;
      m_exc = 32'hF0F0_3C3C; m_gen = 64'h8421_1248_FFFF_0001;
      do_load();
      sweep();
      m_crr = ~m_crr; m_crw = ~m_crw; m_drr = ~m_drr; m_drw = ~m_drw;
      m_exc = ~m_exc; m_gen = ~m_gen;
      do_load();
      sweep();

      // R9: pending exit blocks later events
      m_crr = '1; m_crw = '1; m_drr = '1; m_drw = '1; m_exc = '1; m_gen = '1;
      do_load();
      do_evt('h40, 64'h1);
      chk("R9 first", 64'(exit_req), 64'd1);
      do_evt('h41, 64'h2);
      chk("R9 blocked", 64'(exit_req), 64'd0);
      do_evt('h05, 64'h3);
      chk("R9 still blocked", 64'(exit_req), 64'd0);
      chk("R9 code held", 64'(exit_code), 64'h40);

      // R7: exit_done disarms, entry_load re-arms
      do_exit_done();
      do_evt('h41, 64'h4);
      chk("R7 disarmed exc", 64'(exit_req), 64'd0);
      do_evt('h70, 64'h5);
      chk("R7 disarmed gen", 64'(exit_req), 64'd0);
      do_evt('h02, 64'h6);
      chk("R7 disarmed cr", 64'(exit_req), 64'd0);
      do_load();
      do_evt('h41, 64'h7);
      chk("R7 rearmed", 64'(exit_req), 64'd1);
      chk("R8 param", exit_param, 64'h7);

      // R8: no valid strobe, no exit
      do_load();
      @(negedge clk) evt_code = 12'h041;
      @(negedge clk);
      chk("R8 no strobe", 64'(exit_req), 64'd0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule